// File: doc/BRIEF.md
# Li-ion Charge Sequencer

This block is the digital sequencer of a switched-mode lithium-ion charger. It receives comparator decisions that have already been digitised: supply valid, battery under the low-voltage level, battery under the recharge level, taper current reached, overvoltage, and temperature acceptable. It also receives an active-low enable, a timer/termination enable, a timer-only disable and a free-running 1 ms tick. From these it walks the battery through conditioning (precharge), constant-current (fast) and constant-voltage phases to a completed state. It runs the safety timers, filters the slow comparator flags, latches faults and handles their recovery.

The outputs are a phase code, an enable for the power converter, an enable for the small detection current, a start pulse for an external battery-presence tester whose result comes back on two inputs, two status lines and a power-good line. Every timer and filter counts tick pulses. The fast-phase timeout limit is a 20-bit word held by the host.

Top module: `li_charge_seq`

## Requirements
- R1: While `supply_ok` is low, the phase goes to off (0) one cycle later, and `conv_en`, `det_en`, `stat1` and `stat2` are low. `pgood` follows `supply_ok` in the same cycle. Reset leaves the block in off.
- R2: When the block leaves off with `supply_ok` high and `ce_n` low, it begins a charge if `ce_n` has just fallen or `bat_rch` is high. The charge starts in precharge (1) if `bat_low` is high and in fast (2) otherwise. In any other case it goes to done (4).
- R3: Precharge moves to fast only after `bat_low` has been low for DGL_TICKS ticks. Any change of the flag restarts the count.
- R4: With timers enabled, PRE_TICKS counted ticks in precharge cause a fault (5) and switch the converter off.
- R5: Fast moves to voltage regulation (3) once `bat_rch` is low. A timer counting ticks over the fast and regulation phases raises a fault when it reaches `fast_limit`.
- R6: In voltage regulation with `ttc_en` high, a `term_hit` that stays stable for DGL_TICKS ticks ends the charge in done (4).
- R7: With `ttc_en` low, termination and both timers are disabled. A rising `ttc_en` restarts the cycle with the timers cleared. `tmr_off` high disables only the timers.
- R8: `ce_n` high sends the block to off. A falling `ce_n` starts a new cycle with timers cleared, which also clears a timeout fault.
- R9: From done, a new charge starts once `bat_rch` has been high for DGL_TICKS ticks.
- R10: With `temp_ok` low during a charge phase, `conv_en` and `stat1` are low and both the phase and the timer counts are held. Counting resumes from the held value.
- R11: `ovp` drops `conv_en`, `stat1` and `stat2` in the same cycle and gives fault (5) one cycle later. Restart events are ignored while `ovp` is high. With `ovp` low, the fault clears when `bat_rch` goes high, and a fresh charge follows.
- R12: On a timeout with `bat_rch` high, `det_en` is on until `bat_rch` goes low. When `bat_rch` then rises, the fault clears: the phase shows off (0) and `pres_start` pulses for one cycle. `pres_done` with `pres_ok` high starts a charge; with `pres_ok` low it returns to detection.
- R13: Status: `stat1` is high only while the converter charges, `stat2` only in done, and never both at once. Phase codes: off 0, precharge 1, fast 2, regulation 3, done 4, fault 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | 1 ms time base pulse |
| supply_ok | input | 1 | Input supply valid |
| ce_n | input | 1 | Charge enable, active low |
| ttc_en | input | 1 | Termination and timer enable |
| tmr_off | input | 1 | Disable safety timers only |
| bat_low | input | 1 | Battery below low-voltage level |
| bat_rch | input | 1 | Battery below recharge level |
| term_hit | input | 1 | Charge current at taper level |
| ovp | input | 1 | Battery overvoltage |
| temp_ok | input | 1 | Battery temperature acceptable |
| pres_done | input | 1 | Presence test finished |
| pres_ok | input | 1 | Presence test found a battery |
| fast_limit | input | 20 | Fast-phase timeout in ticks |
| mode | output | 3 | Phase code |
| conv_en | output | 1 | Converter enable |
| det_en | output | 1 | Detection current enable |
| pres_start | output | 1 | One-cycle presence test start |
| stat1 | output | 1 | Charging indication |
| stat2 | output | 1 | Completion indication |
| pgood | output | 1 | Supply good indication |

## Verification
The collision of interest is an overvoltage and a restart request landing in the same cycle. Overvoltage must win: a rising timer-enable edge while overvoltage is held must not reopen a charge. The bench holds `ovp` high, pulses `ttc_en` low and back high, and checks that the phase stays at fault with the converter off. It then confirms that only the recharge-level condition clears the fault. A second overlap is a temperature suspend during a running precharge timer. The bench checks that the fault arrives only after the pre-suspend and post-suspend tick counts together reach the limit.

// File: rtl/chg_pkg.sv
// Shared types for the charge sequencer: internal states, phase codes and
// the index of each filtered comparator flag.
package chg_pkg;
    typedef enum logic [3:0] {
        ST_OFF, ST_PRE, ST_FAST, ST_CV, ST_DONE,
        ST_OVP, ST_TO_DET, ST_TO_WAIT, ST_PROBE
    } chg_st_e;

    typedef enum logic [2:0] {
        MD_OFF   = 3'd0,
        MD_PRE   = 3'd1,
        MD_FAST  = 3'd2,
        MD_CV    = 3'd3,
        MD_DONE  = 3'd4,
        MD_FAULT = 3'd5
    } chg_mode_e;

    localparam int NFLT    = 3;
    localparam int FL_LOWV = 0;  // battery above the low-voltage level
    localparam int FL_TERM = 1;  // taper current reached
    localparam int FL_RCH  = 2;  // battery below the recharge level
endpackage

// File: rtl/chg_dglitch.sv
// Deglitch filter: the output takes the input's value once that value has
// held for N ticks. Any change of the input restarts the count.
// Assumes tick is a one-cycle pulse; the output resets to 0.
module chg_dglitch #(
    parameter int N = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(N + 1);

    logic          prev;
    logic [CW-1:0] cnt;

    // Track the last seen value and count ticks of stability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b0;
            cnt  <= '0;
            filt <= 1'b0;
        end else if (raw != prev) begin
            prev <= raw;
            cnt  <= '0;
        end else if (tick && (filt != prev)) begin
            if (cnt == CW'(N - 1)) begin
                filt <= prev;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_DGL_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt) |-> ($past(cnt) == CW'(N - 1))); // R3
endmodule

// File: rtl/chg_tmr.sv
// Safety timer: counts ticks while run is high, holds otherwise, and
// saturates at the limit. Assumes clr takes priority over counting.
module chg_tmr #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] lim,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Count enabled ticks up to the limit; clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt <= '0;
        else if (clr)                      cnt <= '0;
        else if (run && tick && !expired)  cnt <= cnt + 1'b1;
    end

    // Flag the limit as reached.
    always_comb expired = (cnt >= lim);
endmodule

// File: rtl/li_charge_seq.sv
// Charge sequencer top: phase state machine, flag filters, two safety
// timers and the status decode. Assumes all flag inputs are synchronous
// to clk and that tick is a one-cycle pulse per millisecond.
module li_charge_seq
    import chg_pkg::*;
#(
    parameter int DGL_TICKS = 30,
    parameter int PRE_TICKS = 1800000,
    parameter int FAST_W    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              supply_ok,
    input  logic              ce_n,
    input  logic              ttc_en,
    input  logic              tmr_off,
    input  logic              bat_low,
    input  logic              bat_rch,
    input  logic              term_hit,
    input  logic              ovp,
    input  logic              temp_ok,
    input  logic              pres_done,
    input  logic              pres_ok,
    input  logic [FAST_W-1:0] fast_limit,
    output logic [2:0]        mode,
    output logic              conv_en,
    output logic              det_en,
    output logic              pres_start,
    output logic              stat1,
    output logic              stat2,
    output logic              pgood
);
    localparam int PRE_W = $clog2(PRE_TICKS + 1);
    localparam logic [PRE_W-1:0] PRE_LIM = PRE_W'(PRE_TICKS);

    chg_st_e          st, nxt;
    logic             ce_q, ttc_q, go_start, pres_q;
    logic [NFLT-1:0]  raw_v, flt;
    logic             pre_exp, fast_exp;

    wire active   = supply_ok & ~ce_n;
    wire restart  = (ce_q & ~ce_n) | (~ttc_q & ttc_en);
    wire tmr_en   = ttc_en & ~tmr_off;
    wire charging = (st == ST_PRE) || (st == ST_FAST) || (st == ST_CV);
    wire chg_st_e start_st = bat_low ? ST_PRE : ST_FAST;
    wire chg_st_e flt_st   = bat_rch ? ST_TO_DET : ST_TO_WAIT;

    assign raw_v = {bat_rch, term_hit, ~bat_low};

    genvar g;
    generate
        for (g = 0; g < NFLT; g++) begin : g_flt
            chg_dglitch #(.N(DGL_TICKS)) u_dgl (
                .clk(clk), .rst_n(rst_n), .tick(tick),
                .raw(raw_v[g]), .filt(flt[g])
            );
        end
    endgenerate

    chg_tmr #(.W(PRE_W)) u_pre_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(go_start),
        .run(st == ST_PRE && temp_ok && tmr_en && !ovp),
        .lim(PRE_LIM), .expired(pre_exp)
    );

    chg_tmr #(.W(FAST_W)) u_fast_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(go_start),
        .run((st == ST_FAST || st == ST_CV) && temp_ok && tmr_en && !ovp),
        .lim(fast_limit), .expired(fast_exp)
    );

    // Next-state selection with sleep, overvoltage, restart priority.
    always_comb begin
        nxt      = st;
        go_start = 1'b0;
        if (!active) begin
            nxt = ST_OFF;
        end else if (ovp) begin
            nxt = ST_OVP;
        end else if (st == ST_OFF) begin
            go_start = (ce_q & ~ce_n) | bat_rch;
            nxt      = go_start ? start_st : ST_DONE;
        end else if (restart && st != ST_OVP) begin
            go_start = 1'b1;
            nxt      = start_st;
        end else begin
            unique case (st)
                ST_PRE: if (temp_ok) begin
                    if (pre_exp && tmr_en)  nxt = flt_st;
                    else if (flt[FL_LOWV])  nxt = ST_FAST;
                end
                ST_FAST: if (temp_ok) begin
                    if (fast_exp && tmr_en) nxt = flt_st;
                    else if (!bat_rch)      nxt = ST_CV;
                end
                ST_CV: if (temp_ok) begin
                    if (fast_exp && tmr_en)          nxt = flt_st;
                    else if (ttc_en && flt[FL_TERM]) nxt = ST_DONE;
                end
                ST_DONE: if (flt[FL_RCH] && bat_rch) begin
                    go_start = 1'b1;
                    nxt      = start_st;
                end
                ST_OVP: if (bat_rch) begin
                    go_start = 1'b1;
                    nxt      = start_st;
                end
                ST_TO_DET:  if (!bat_rch) nxt = ST_TO_WAIT;
                ST_TO_WAIT: if (bat_rch)  nxt = ST_PROBE;
                ST_PROBE: if (pres_done) begin
                    go_start = pres_ok;
                    nxt      = pres_ok ? start_st : ST_TO_DET;
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    // State, edge-detect history and presence start pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_OFF;
            ce_q   <= 1'b0;
            ttc_q  <= 1'b1;
            pres_q <= 1'b0;
        end else begin
            st     <= nxt;
            ce_q   <= ce_n;
            ttc_q  <= ttc_en;
            pres_q <= (nxt == ST_PROBE) && (st != ST_PROBE);
        end
    end

    // Phase code decode for the mode output.
    always_comb begin
        unique case (st)
            ST_PRE:  mode = MD_PRE;
            ST_FAST: mode = MD_FAST;
            ST_CV:   mode = MD_CV;
            ST_DONE: mode = MD_DONE;
            ST_OVP, ST_TO_DET, ST_TO_WAIT: mode = MD_FAULT;
            default: mode = MD_OFF;
        endcase
    end

    // Converter, detection and status line decode.
    always_comb begin
        conv_en    = charging && temp_ok && !ovp;
        stat1      = conv_en;
        stat2      = (st == ST_DONE) && !ovp;
        det_en     = (st == ST_TO_DET);
        pres_start = pres_q;
        pgood      = supply_ok;
    end

    AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (st == ST_OFF)); // R1
    AST_OVP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ovp && active) |=> (st == ST_OVP)); // R11
    AST_TERM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && $past(st) == ST_CV) |-> $past(ttc_en)); // R6
    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PRE && !temp_ok && active && !ovp && !restart) |=> (st == ST_PRE)); // R10
    AST_STAT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat1 && stat2)); // R13
    AST_DET_NO_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        det_en |-> !conv_en); // R12
    AST_PROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pres_start |=> !pres_start); // R12
endmodule

// File: tb/li_charge_seq_test.sv
module li_charge_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        supply_ok = 1'b0, ce_n = 1'b0, ttc_en = 1'b1, tmr_off = 1'b0;
    logic        bat_low = 1'b1, bat_rch = 1'b1, term_hit = 1'b0, ovp = 1'b0;
    logic        temp_ok = 1'b1, pres_done = 1'b0, pres_ok = 1'b0;
    logic [19:0] fast_limit = 20'd400;
    logic [2:0]  mode;
    logic        conv_en, det_en, pres_start, stat1, stat2, pgood;
    int          total = 0, fails = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    li_charge_seq #(.DGL_TICKS(30), .PRE_TICKS(200), .FAST_W(20)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
        .ce_n(ce_n), .ttc_en(ttc_en), .tmr_off(tmr_off), .bat_low(bat_low),
        .bat_rch(bat_rch), .term_hit(term_hit), .ovp(ovp), .temp_ok(temp_ok),
        .pres_done(pres_done), .pres_ok(pres_ok), .fast_limit(fast_limit),
        .mode(mode), .conv_en(conv_en), .det_en(det_en),
        .pres_start(pres_start), .stat1(stat1), .stat2(stat2), .pgood(pgood)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        step(3);
        check("R1 reset mode", mode, 0);
        check("R1 reset conv", conv_en, 0);
        check("R1 reset pgood", pgood, 0);
        rst_n = 1'b1;
        step(2);
        check("R1 idle stat", {stat1, stat2, det_en}, 0);
    endtask

    task automatic t_power_precharge();
        supply_ok = 1'b1;
        #1 check("R1 pgood follows", pgood, 1);
        step(2);
        check("R2 starts precharge", mode, 1);
        check("R13 charging status", {stat1, stat2}, 2'b10);
        check("R13 converter on", conv_en, 1);
    endtask

    task automatic t_lowv_deglitch();
        bat_low = 1'b0;
        step(20);
        check("R3 early hold", mode, 1);
        bat_low = 1'b1;
        step(1);
        bat_low = 1'b0;
        step(20);
        check("R3 glitch restarts", mode, 1);
        step(15);
        check("R3 fast after window", mode, 2);
    endtask

    task automatic t_cv_term();
        bat_rch = 1'b0;
        step(2);
        check("R5 enter regulation", mode, 3);
        term_hit = 1'b1;
        step(15);
        check("R6 term early", mode, 3);
        step(25);
        check("R6 done", mode, 4);
        check("R13 done status", {stat1, stat2, conv_en}, 3'b010);
    endtask

    task automatic t_ttc_disable();
        ttc_en = 1'b0;
        ce_n = 1'b1;
        step(2);
        check("R8 ce high sleeps", mode, 0);
        check("R8 status off", {stat1, stat2}, 0);
        ce_n = 1'b0;
        step(3);
        check("R8 fall restarts", mode, 3);
        step(100);
        check("R7 term disabled", mode, 3);
        ttc_en = 1'b1;
        step(4);
        check("R7 rise restarts", mode, 4);
    endtask

    task automatic t_recharge();
        term_hit = 1'b0;
        fast_limit = 20'd100;
        bat_rch = 1'b1;
        step(15);
        check("R9 early hold", mode, 4);
        step(25);
        check("R9 recharge fast", mode, 2);
    endtask

    task automatic t_timeout_recover();
        int pulses = 0;
        step(50);
        check("R5 before limit", mode, 2);
        step(60);
        check("R5 fast timeout", mode, 5);
        check("R12 detect on", det_en, 1);
        check("R12 conv off", conv_en, 0);
        bat_rch = 1'b0;
        step(2);
        check("R12 detect off above", det_en, 0);
        check("R12 still fault", mode, 5);
        bat_rch = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step(1);
            if (pres_start) pulses++;
        end
        check("R12 single start pulse", pulses, 1);
        check("R12 probe mode", mode, 0);
        pres_done = 1'b1;
        pres_ok = 1'b0;
        step(2);
        check("R12 absent back to detect", det_en, 1);
        pres_done = 1'b0;
        bat_rch = 1'b0;
        step(2);
        bat_rch = 1'b1;
        step(3);
        pres_done = 1'b1;
        pres_ok = 1'b1;
        step(2);
        check("R12 present charges", mode, 2);
        pres_done = 1'b0;
    endtask

    task automatic t_pre_timeout_suspend();
        ce_n = 1'b1;
        bat_low = 1'b1;
        bat_rch = 1'b1;
        step(40);
        ce_n = 1'b0;
        step(2);
        check("R2 precharge again", mode, 1);
        step(100);
        temp_ok = 1'b0;
        step(2);
        check("R10 conv off", {conv_en, stat1}, 0);
        check("R10 phase held", mode, 1);
        step(300);
        check("R10 long suspend", mode, 1);
        temp_ok = 1'b1;
        step(50);
        check("R10 timer held", mode, 1);
        step(60);
        check("R4 pre timeout", mode, 5);
        check("R4 detect only", {det_en, conv_en}, 2'b10);
    endtask

    task automatic t_tmr_off();
        ce_n = 1'b1;
        step(2);
        tmr_off = 1'b1;
        ce_n = 1'b0;
        step(2);
        check("R8 fault cleared", mode, 1);
        step(250);
        check("R7 timer off", mode, 1);
        tmr_off = 1'b0;
    endtask

    task automatic t_ovp();
        ovp = 1'b1;
        #1 check("R11 immediate off", {conv_en, stat1, stat2}, 0);
        step(2);
        check("R11 fault", mode, 5);
        ttc_en = 1'b0;
        step(1);
        ttc_en = 1'b1;
        step(3);
        check("R11 restart ignored", mode, 5);
        check("R11 conv held off", conv_en, 0);
        ovp = 1'b0;
        bat_rch = 1'b0;
        step(3);
        check("R11 waits recharge", mode, 5);
        bat_rch = 1'b1;
        step(2);
        check("R11 cleared", mode, 1);
    endtask

    task automatic t_sleep_por();
        supply_ok = 1'b0;
        #1 check("R1 pgood off", pgood, 0);
        step(2);
        check("R1 sleep mode", mode, 0);
        check("R1 sleep outs", {conv_en, stat1, stat2, det_en}, 0);
        bat_low = 1'b0;
        bat_rch = 1'b0;
        step(1);
        supply_ok = 1'b1;
        step(2);
        check("R2 full battery done", mode, 4);
        check("R13 done stat2", stat2, 1);
    endtask

    initial begin
        t_reset();
        t_power_precharge();
        t_lowv_deglitch();
        t_cv_term();
        t_ttc_disable();
        t_recharge();
        t_timeout_recover();
        t_pre_timeout_suspend();
        t_tmr_off();
        t_ovp();
        t_sleep_por();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule